// File: doc/BRIEF.md
# Cycle-Stealing Single-Channel DMA Engine

This block moves a programmed number of words between one attached peripheral and system memory, taking the shared bus for a single bus cycle per word. Software fills in the transfer direction, the peripheral address, the first memory address and the number of words, then writes a start bit. From then on the engine waits until the peripheral is able to take part in a word, asks the bus arbiter for the bus, moves that one word on the granted cycle, and drops its request again. The processor keeps running and loses only the bus cycles that the engine takes. It never switches context.

The engine sits beside its peripheral. On each word, the data passes over the system bus once, directly between memory and the peripheral port. After each word the memory pointer moves up by one and the remaining count goes down by one. When the count reaches zero the engine raises a level interrupt. The interrupt stays high until software clears it.

Top module: `steal_dma`

## Requirements
- R1: After reset, `bus_req`, `irq` and all four strobes (`mem_we`, `mem_re`, `dev_we`, `dev_re`) are low, and the status register (offset 4) reads 0.
- R2: While the engine is idle, the configuration registers read back exactly what was written. The registers are: control at offset 0 (bit 0 = direction, 1 = device to memory, 0 = memory to device), peripheral address at offset 1, memory address at offset 2 and word count at offset 3. All fields are zero-extended on read.
- R3: While a transfer is active (status bit 0 = busy), writes to offsets 0–3 leave every configuration register unchanged, and a second start is ignored.
- R4: `bus_req` rises only while `dev_ready` is high. While the engine is waiting with `dev_ready` high and no grant, it holds `bus_req` high and moves no data.
- R5: Each grant carries exactly one word. The transfer cycle comes one cycle after a grant is seen. `bus_req` is then low for at least one cycle before the next word is requested, so two transfer cycles are never adjacent.
- R6: In device-to-memory mode, the transfer cycle asserts `dev_re` and `mem_we` together. It drives `mem_wdata` from `dev_rdata`, `mem_addr` from the current memory pointer, and `dev_addr` from the programmed peripheral address.
- R7: In memory-to-device mode, the transfer cycle asserts `mem_re` and `dev_we` together, and drives `dev_wdata` from `mem_rdata`.
- R8: After each word, the memory address register goes up by one and the count register goes down by one. Both are readable at their offsets.
- R9: When the last word is done, `irq` and status bit 1 (done) go high and busy falls. `irq` stays high until control bit 2 (clear) is written as 1; a new start also clears it.
- R10: Starting with a count of zero causes no bus request and no transfer. `irq` rises two clock edges after the start write is sampled.
- R11: No memory or peripheral strobe is asserted unless `bus_req` is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | RW | Register write data |
| reg_rdata | output | RW | Register read data (combinational on reg_addr) |
| irq | output | 1 | Completion interrupt, level |
| bus_req | output | 1 | Bus request to arbiter |
| bus_gnt | input | 1 | Bus grant from arbiter |
| mem_addr | output | AW | Memory word address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, same-cycle |
| dev_addr | output | AW | Peripheral address |
| dev_ready | input | 1 | Peripheral has data (to memory) or room (from memory) |
| dev_we | output | 1 | Peripheral write strobe |
| dev_re | output | 1 | Peripheral read strobe |
| dev_wdata | output | DW | Peripheral write data |
| dev_rdata | input | DW | Peripheral read data, same-cycle |

## Verification
The hardest state to reach is a transfer that is in flight but stalled. In that state, writes must bounce off the register file, and a request must be held without data moving. The bench starts a transfer with the peripheral not ready and attempts reconfiguration while busy. It then raises readiness while the arbiter model withholds the grant. It lets words flow only after checking that the request stays high and nothing has moved. A bus monitor counts request edges and transfer cycles, so that one word per grant and the release gap between words can be checked over whole transfers.

// File: rtl/steal_dma_pkg.sv
`timescale 1ns/1ps
package steal_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_XFER,
    ST_REL
  } seq_state_e;

  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_DEV  = 3'd1;
  localparam logic [2:0] OFS_MEM  = 3'd2;
  localparam logic [2:0] OFS_CNT  = 3'd3;
  localparam logic [2:0] OFS_STAT = 3'd4;

  localparam int unsigned BIT_DIR = 0;
  localparam int unsigned BIT_GO  = 1;
  localparam int unsigned BIT_CLR = 2;
endpackage

// File: rtl/steal_dma_regs.sv
`timescale 1ns/1ps
module steal_dma_regs
  import steal_dma_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16,
  parameter int unsigned RW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [2:0]    addr,
  input  logic [RW-1:0] wdata,
  output logic [RW-1:0] rdata,
  input  logic          busy,
  input  logic          step,
  input  logic          finish,
  output logic          dir,
  output logic [AW-1:0] dev_ptr,
  output logic [AW-1:0] mem_ptr,
  output logic [CW-1:0] count,
  output logic          done,
  output logic          go
);
  localparam int unsigned FW = (AW > CW) ? AW : CW;

  logic          dir_q, dir_d, done_q, done_d;
  logic [AW-1:0] dev_q, dev_d, mem_q, mem_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cfg_en, sel_ctrl, sel_dev, sel_mem, sel_cnt, clr;
  logic          unused_hi;

  assign unused_hi = ^wdata[RW-1:FW];
  assign cfg_en    = wr && !busy;
  assign sel_ctrl  = cfg_en && (addr == OFS_CTRL);
  assign sel_dev   = cfg_en && (addr == OFS_DEV);
  assign sel_mem   = cfg_en && (addr == OFS_MEM);
  assign sel_cnt   = cfg_en && (addr == OFS_CNT);
  assign go        = sel_ctrl && wdata[BIT_GO];
  assign clr       = wr && (addr == OFS_CTRL) && wdata[BIT_CLR];

  always_comb begin
    dir_d  = dir_q;
    dev_d  = dev_q;
    mem_d  = mem_q;
    cnt_d  = cnt_q;
    done_d = done_q;
    if (sel_ctrl) dir_d = wdata[BIT_DIR];
    if (sel_dev)  dev_d = wdata[AW-1:0];
    if (step)          mem_d = mem_q + 1'b1;
    else if (sel_mem)  mem_d = wdata[AW-1:0];
    if (step)          cnt_d = cnt_q - 1'b1;
    else if (sel_cnt)  cnt_d = wdata[CW-1:0];
    if (finish)            done_d = 1'b1;
    else if (go || clr)    done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      dev_q  <= '0;
      mem_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      dir_q  <= dir_d;
      dev_q  <= dev_d;
      mem_q  <= mem_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_CTRL: rdata[BIT_DIR] = dir_q;
      OFS_DEV:  rdata[AW-1:0]  = dev_q;
      OFS_MEM:  rdata[AW-1:0]  = mem_q;
      OFS_CNT:  rdata[CW-1:0]  = cnt_q;
      OFS_STAT: rdata[1:0]     = {done_q, busy};
      default:  rdata          = '0;
    endcase
  end

  assign dir     = dir_q;
  assign dev_ptr = dev_q;
  assign mem_ptr = mem_q;
  assign count   = cnt_q;
  assign done    = done_q;
endmodule

// File: rtl/steal_dma_seq.sv
`timescale 1ns/1ps
module steal_dma_seq
  import steal_dma_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [CW-1:0] count,
  input  logic          dev_ready,
  input  logic          bus_gnt,
  output logic          bus_req,
  output logic          xfer,
  output logic          finish,
  output logic          busy
);
  seq_state_e state_q, state_d;
  logic       last;

  assign last = (count == '0);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (go) state_d = last ? ST_REL : ST_WAIT;
      ST_WAIT: if (dev_ready && bus_gnt) state_d = ST_XFER;
      ST_XFER: state_d = ST_REL;
      ST_REL:  state_d = last ? ST_IDLE : ST_WAIT;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign bus_req = ((state_q == ST_WAIT) && dev_ready) || (state_q == ST_XFER);
  assign xfer    = (state_q == ST_XFER);
  assign finish  = (state_q == ST_REL) && last;
  assign busy    = (state_q != ST_IDLE);
endmodule

// File: rtl/steal_dma_path.sv
`timescale 1ns/1ps
module steal_dma_path #(
  parameter int unsigned DW = 16
) (
  input  logic          xfer,
  input  logic          dir,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] dev_rdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic          dev_we,
  output logic          dev_re,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] dev_wdata
);
  assign mem_we    = xfer && dir;
  assign dev_re    = xfer && dir;
  assign mem_re    = xfer && !dir;
  assign dev_we    = xfer && !dir;
  assign mem_wdata = dev_rdata;
  assign dev_wdata = mem_rdata;
endmodule

// File: rtl/steal_dma.sv
`timescale 1ns/1ps
module steal_dma #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 16,
  parameter int unsigned RW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  output logic          irq,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] dev_addr,
  input  logic          dev_ready,
  output logic          dev_we,
  output logic          dev_re,
  output logic [DW-1:0] dev_wdata,
  input  logic [DW-1:0] dev_rdata
);
  logic          busy, xfer, finish, go, dir, done;
  logic [CW-1:0] count;

  steal_dma_regs #(.AW(AW), .CW(CW), .RW(RW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy), .step(xfer),
    .finish(finish), .dir(dir), .dev_ptr(dev_addr), .mem_ptr(mem_addr),
    .count(count), .done(done), .go(go)
  );

  steal_dma_seq #(.CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .count(count),
    .dev_ready(dev_ready), .bus_gnt(bus_gnt), .bus_req(bus_req),
    .xfer(xfer), .finish(finish), .busy(busy)
  );

  steal_dma_path #(.DW(DW)) u_path (
    .xfer(xfer), .dir(dir), .mem_rdata(mem_rdata), .dev_rdata(dev_rdata),
    .mem_we(mem_we), .mem_re(mem_re), .dev_we(dev_we), .dev_re(dev_re),
    .mem_wdata(mem_wdata), .dev_wdata(dev_wdata)
  );

  assign irq = done;
endmodule

// File: rtl/steal_dma_chk.sv
`timescale 1ns/1ps
module steal_dma_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [2:0]    reg_addr,
  input logic [1:0]    ctl_bits,
  input logic          irq,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          dev_ready,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          mem_re,
  input logic          dev_we,
  input logic          dev_re
);
  logic any_xfer, irq_drop_ok;
  assign any_xfer    = mem_we || mem_re;
  assign irq_drop_ok = reg_wr && (reg_addr == 3'd0) && (ctl_bits != 2'b00);

  // R11: strobes only while the bus is held
  p_strobe_needs_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re || dev_we || dev_re) |-> bus_req);

  // R4: a request starts only with the peripheral ready
  p_req_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> dev_ready);

  // R5: one word per grant, bus released afterwards
  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    any_xfer |=> !bus_req);

  p_after_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    any_xfer |-> $past(bus_gnt));

  // R6 / R7: direction pairs never mix
  p_dir_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !((mem_we || dev_re) && (mem_re || dev_we)));

  // R8: pointer advances by one per word
  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any_xfer |=> (mem_addr == AW'($past(mem_addr) + 1'b1)));

  // R9: interrupt held until cleared or restarted
  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_drop_ok) |=> irq);
endmodule

bind steal_dma steal_dma_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .ctl_bits(reg_wdata[2:1]), .irq(irq), .bus_req(bus_req),
  .bus_gnt(bus_gnt), .dev_ready(dev_ready), .mem_addr(mem_addr),
  .mem_we(mem_we), .mem_re(mem_re), .dev_we(dev_we), .dev_re(dev_re)
);

// File: tb/steal_dma_bench.sv
`timescale 1ns/1ps
module steal_dma_bench;
  localparam int AW = 16, DW = 16, CW = 16, RW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [RW-1:0] reg_wdata = '0, reg_rdata;
  logic irq, bus_req, bus_gnt;
  logic [AW-1:0] mem_addr, dev_addr;
  logic mem_we, mem_re, dev_we, dev_re;
  logic [DW-1:0] mem_wdata, mem_rdata, dev_wdata, dev_rdata;
  logic dev_ready = 1'b0;
  logic gnt_allow = 1'b1;

  always #5 clk = ~clk;

  steal_dma #(.AW(AW), .DW(DW), .CW(CW), .RW(RW)) u_steal_dma (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .dev_addr(dev_addr), .dev_ready(dev_ready),
    .dev_we(dev_we), .dev_re(dev_re), .dev_wdata(dev_wdata),
    .dev_rdata(dev_rdata)
  );

  // memory, peripheral and arbiter models
  logic [DW-1:0] mem [0:255];
  logic [DW-1:0] dev_buf [0:15];
  int dev_idx = 0;
  assign mem_rdata = mem[mem_addr[7:0]];
  assign dev_rdata = 16'hD000 + DW'(dev_idx);

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (dev_we) dev_buf[dev_idx[3:0]] <= dev_wdata;
    if (dev_we || dev_re) dev_idx <= dev_idx + 1;
  end

  always @(posedge clk or negedge rst_n)
    if (!rst_n) bus_gnt <= 1'b0;
    else        bus_gnt <= bus_req && gnt_allow;

  // bus monitor
  int req_rises = 0, req_unready = 0, xfers = 0, b2b = 0, addr_bad = 0, nobus = 0;
  logic prev_req = 1'b0, prev_x = 1'b0;
  logic [AW-1:0] exp_dev = '0;
  always begin
    @(posedge clk); #2;
    if (rst_n) begin
      if (bus_req && !prev_req) begin
        req_rises++;
        if (!dev_ready) req_unready++;
      end
      if (mem_we || mem_re) begin
        xfers++;
        if (prev_x) b2b++;
        if (dev_addr !== exp_dev) addr_bad++;
      end
      if ((mem_we || mem_re || dev_we || dev_re) && !bus_req) nobus++;
      prev_req = bus_req;
      prev_x   = mem_we || mem_re;
    end
  end

  int checks = 0, errors = 0;
  bit summary_done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic clr_stats();
    @(negedge clk);
    req_rises = 0; req_unready = 0; xfers = 0; b2b = 0; addr_bad = 0; nobus = 0;
    dev_idx = 0;
  endtask

  task automatic wait_irq(input string tag);
    for (int i = 0; i < 2000 && !irq; i++) @(negedge clk);
    chk(tag, irq, 1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 bus_req", bus_req, 0);
    chk("R1 irq", irq, 0);
    chk("R1 strobes", {mem_we, mem_re, dev_we, dev_re}, 0);
    rd_reg(3'd4, v);
    chk("R1 status", v, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr_reg(3'd1, 32'h0000_1234);
    wr_reg(3'd2, 32'h0000_0040);
    wr_reg(3'd3, 32'h0000_0003);
    wr_reg(3'd0, 32'h0000_0001);
    rd_reg(3'd1, v); chk("R2 dev addr", v, 32'h1234);
    rd_reg(3'd2, v); chk("R2 mem addr", v, 32'h40);
    rd_reg(3'd3, v); chk("R2 count", v, 32'h3);
    rd_reg(3'd0, v); chk("R2 dir", v, 32'h1);
    chk("R2 no start", bus_req, 0);
  endtask

  task automatic t_dev_to_mem();
    logic [31:0] v;
    clr_stats();
    exp_dev = 16'h0012; dev_ready = 1'b1; gnt_allow = 1'b1;
    wr_reg(3'd1, 32'h12);
    wr_reg(3'd2, 32'h40);
    wr_reg(3'd3, 32'd4);
    wr_reg(3'd0, 32'h3);
    wait_irq("R9 irq d2m");
    for (int i = 0; i < 4; i++)
      chk("R6 mem data", mem[8'h40 + i], 32'hD000 + i);
    chk("R6 dev addr", addr_bad, 0);
    chk("R5 words", xfers, 4);
    chk("R5 one per request", req_rises, 4);
    chk("R5 no back-to-back", b2b, 0);
    chk("R11 strobes on bus", nobus, 0);
    rd_reg(3'd2, v); chk("R8 mem addr end", v, 32'h44);
    rd_reg(3'd3, v); chk("R8 count end", v, 0);
    rd_reg(3'd4, v); chk("R9 status done idle", v, 32'h2);
  endtask

  task automatic t_mem_to_dev();
    clr_stats();
    for (int i = 0; i < 3; i++) mem[8'h80 + i] = 16'hB000 + 16'(i);
    exp_dev = 16'h0021; dev_ready = 1'b1;
    wr_reg(3'd1, 32'h21);
    wr_reg(3'd2, 32'h80);
    wr_reg(3'd3, 32'd3);
    wr_reg(3'd0, 32'h2);
    chk("R9 start clears irq", irq, 0);
    wait_irq("R9 irq m2d");
    for (int i = 0; i < 3; i++)
      chk("R7 dev data", dev_buf[i], 32'hB000 + i);
    chk("R7 words", xfers, 3);
    chk("R7 dev addr", addr_bad, 0);
  endtask

  task automatic t_irq_hold();
    logic [31:0] v;
    repeat (10) @(negedge clk);
    chk("R9 irq held", irq, 1);
    wr_reg(3'd0, 32'h4);
    chk("R9 irq cleared", irq, 0);
    rd_reg(3'd4, v); chk("R9 done cleared", v, 0);
  endtask

  task automatic t_busy_lock();
    logic [31:0] v;
    clr_stats();
    dev_ready = 1'b0; exp_dev = 16'h0055;
    wr_reg(3'd1, 32'h55);
    wr_reg(3'd2, 32'h10);
    wr_reg(3'd3, 32'd2);
    wr_reg(3'd0, 32'h3);
    repeat (6) @(negedge clk);
    chk("R4 no req unready", req_rises, 0);
    wr_reg(3'd2, 32'h99);
    wr_reg(3'd3, 32'd7);
    wr_reg(3'd1, 32'h77);
    wr_reg(3'd0, 32'h2);
    rd_reg(3'd2, v); chk("R3 mem locked", v, 32'h10);
    rd_reg(3'd3, v); chk("R3 count locked", v, 32'd2);
    rd_reg(3'd1, v); chk("R3 dev locked", v, 32'h55);
    rd_reg(3'd0, v); chk("R3 dir locked", v, 32'h1);
    rd_reg(3'd4, v); chk("R3 busy", v, 32'h1);
    gnt_allow = 1'b0; dev_ready = 1'b1;
    repeat (5) @(negedge clk);
    chk("R4 req held", bus_req, 1);
    chk("R4 no move w/o grant", xfers, 0);
    gnt_allow = 1'b1;
    wait_irq("R9 irq stalled");
    rd_reg(3'd2, v); chk("R3 R8 mem addr", v, 32'h12);
    chk("R3 words", xfers, 2);
    chk("R4 ready at req", req_unready, 0);
    chk("R6 dev addr", addr_bad, 0);
    wr_reg(3'd0, 32'h4);
  endtask

  task automatic t_zero();
    clr_stats();
    wr_reg(3'd3, 32'd0);
    wr_reg(3'd0, 32'h3);
    chk("R10 irq not yet", irq, 0);
    @(negedge clk);
    chk("R10 irq", irq, 1);
    chk("R10 no request", req_rises, 0);
    chk("R10 no transfer", xfers, 0);
    wr_reg(3'd0, 32'h4);
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 16; i++) dev_buf[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_dev_to_mem();
    t_mem_to_dev();
    t_irq_hold();
    t_busy_lock();
    t_zero();
    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end
endmodule